// File: doc/BRIEF.md
# Prioritized CPU Exception Arbiter

This block decides which exception handling sequence a CPU starts next. It watches the reset pin, a watchdog overflow strobe, a pending interrupt request, trap instruction strobes and the trace flag. It also watches a strobe from the instruction sequencer that marks the end of each instruction or exception sequence. At every accept point it resolves the candidates in a fixed order (reset, trace, interrupt, trap) and issues a single-cycle one-hot grant with a matching exception code. Candidates that lose stay available for later boundaries.

Reset handling does not wait for an instruction boundary. It starts on a rising edge of the reset pin, or on a watchdog overflow while the CPU is executing. The NMI pin level at that moment selects power-on or manual reset. Boundary sampling has its own rules. Interrupts are not sampled after a condition-register modify instruction or after reset handling completes. Trace is never taken after a return-from-exception. Trace exists only in one interrupt control mode.

Top module: `exc_arbiter`

## Requirements
- R1: `grant` has at most one bit set. Bit 0 is reset, bit 1 trace, bit 2 interrupt and bit 3 trap. Whenever a bit k is set, `exc_code` equals k; otherwise it is 0. Every grant lasts exactly one cycle.
- R2: When several candidates qualify at the same accept point, only the highest-priority one is granted (reset > trace > interrupt > trap). A latched trap and a still-asserted interrupt are granted at later boundaries.
- R3: A low-to-high transition of `res_pin`, or `wdt_ovf` while in the program execution state, raises `grant[0]` in the next cycle. This needs no boundary strobe and is not held off by `busy`.
- R4: At each reset start, `rst_is_por` takes the value of `nmi_pin` sampled with the start (1 = power-on, 0 = manual) and holds it until the next reset start. After system reset it reads 1.
- R5: Trace is granted at a boundary only if `trace_flag` is 1 and `intm` equals 2. In any other mode the flag has no effect.
- R6: No trace grant follows a boundary whose `bnd_kind` is 2 (return-from-exception).
- R7: A pending interrupt is granted at a boundary unless `bnd_kind` is 1 (condition-register modify) or 3 (reset handling done). A request still held is granted at the next allowed boundary. Kind 0 and kinds 4 to 7 are normal boundaries.
- R8: A `trap_req` strobe in the program execution state is latched. It is granted at a boundary whatever the mode, trace flag or boundary kind, once no higher candidate qualifies.
- R9: Trace, interrupt and trap grants appear only in the cycle after a cycle with `bnd_valid` high and `busy` low.
- R10: After system reset, no grant is issued until a rising edge of `res_pin` has been seen. While `res_pin` is low, no grant is issued. A latched trap is discarded when `res_pin` is low and at every reset start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| res_pin | input | 1 | CPU reset pin level, low = held in reset |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| nmi_pin | input | 1 | NMI pin level, selects reset type |
| irq_pend | input | 1 | Interrupt request pending (level) |
| trap_req | input | 1 | Trap instruction strobe |
| trace_flag | input | 1 | Trace flag from the status register |
| intm | input | MODE_W | Interrupt control mode |
| bnd_valid | input | 1 | Instruction or exception sequence boundary |
| bnd_kind | input | KIND_W | Kind of sequence that just completed |
| busy | input | 1 | An exception sequence is in progress |
| grant | output | 4 | One-hot exception start pulse |
| rst_is_por | output | 1 | 1 = power-on reset, 0 = manual reset |
| exc_code | output | 2 | Index of the granted exception |

## Verification
The bench targets several corner cases where a wrong design would show a visible error:
- Trace, interrupt and trap all arrive at one boundary. A wrong priority order would start the trap or the interrupt first, or drop the losers instead of serving them later.
- Boundaries after condition-register modifies and after reset completion. A design that ignored the tag would take the interrupt too early.
- Boundaries after a return-from-exception, and in the wrong control mode. A bad design would start a spurious trace.
- A trap latched just before the reset pin falls. A design that kept it would start a stale trap after reset.
- A watchdog overflow with the NMI pin low. A design that misclassified it would report power-on.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned CODE_W  = $clog2(NUM_SRC);
  localparam int unsigned KIND_W  = 3;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET = 2'd0,
    EXC_TRACE = 2'd1,
    EXC_IRQ   = 2'd2,
    EXC_TRAP  = 2'd3
  } exc_code_e;

  typedef enum logic [KIND_W-1:0] {
    KIND_NORMAL   = 3'd0,
    KIND_CCR_MOD  = 3'd1,
    KIND_RET_EXC  = 3'd2,
    KIND_RST_DONE = 3'd3
  } bnd_kind_e;
endpackage

// File: rtl/exc_reset_ctl.sv
module exc_reset_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic res_pin,
  input  logic wdt_ovf,
  input  logic nmi_pin,
  output logic rst_start,
  output logic exec_st,
  output logic rst_is_por
);
  logic res_q, res_d;
  logic armed_q, armed_d;
  logic por_q, por_d;

  always_comb begin
    exec_st   = armed_q & res_pin;
    rst_start = (res_pin & ~res_q) | (wdt_ovf & exec_st);
    res_d     = res_pin;
    armed_d   = armed_q | rst_start;
    por_d     = rst_start ? nmi_pin : por_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= 1'b1;
      armed_q <= 1'b0;
      por_q   <= 1'b1;
    end else begin
      res_q   <= res_d;
      armed_q <= armed_d;
      por_q   <= por_d;
    end
  end

  assign rst_is_por = por_q;
endmodule

// File: rtl/exc_req_qual.sv
module exc_req_qual
  import exc_arb_pkg::*;
#(
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned TRACE_MODE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_st,
  input  logic               rst_start,
  input  logic               bnd_valid,
  input  logic [KIND_W-1:0]  bnd_kind,
  input  logic               busy,
  input  logic               trace_flag,
  input  logic [MODE_W-1:0]  intm,
  input  logic               irq_pend,
  input  logic               trap_req,
  input  logic               trap_taken,
  output logic [NUM_SRC-1:0] req
);
  logic trap_q, trap_d;
  logic accept, trace_ok, irq_ok, trap_ok;

  always_comb begin
    accept   = bnd_valid & exec_st & ~busy & ~rst_start;
    trace_ok = trace_flag & (intm == MODE_W'(TRACE_MODE))
             & (bnd_kind != KIND_RET_EXC);
    irq_ok   = irq_pend & (bnd_kind != KIND_CCR_MOD)
             & (bnd_kind != KIND_RST_DONE);
    trap_ok  = exec_st & (trap_q | trap_req);

    req            = '0;
    req[EXC_RESET] = rst_start;
    req[EXC_TRACE] = accept & trace_ok;
    req[EXC_IRQ]   = accept & irq_ok;
    req[EXC_TRAP]  = accept & trap_ok;

    if (!exec_st || rst_start) trap_d = 1'b0;
    else                       trap_d = trap_ok & ~trap_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end
endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx
);
  logic [N-1:0] seen;

  assign gnt[0]  = req[0];
  assign seen[0] = req[0];

  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_chain
      assign gnt[g]  = req[g] & ~seen[g-1];
      assign seen[g] = seen[g-1] | req[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) idx = IW'(i);
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_arb_pkg::*;
#(
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned TRACE_MODE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_pin,
  input  logic               wdt_ovf,
  input  logic               nmi_pin,
  input  logic               irq_pend,
  input  logic               trap_req,
  input  logic               trace_flag,
  input  logic [MODE_W-1:0]  intm,
  input  logic               bnd_valid,
  input  logic [KIND_W-1:0]  bnd_kind,
  input  logic               busy,
  output logic [NUM_SRC-1:0] grant,
  output logic               rst_is_por,
  output logic [CODE_W-1:0]  exc_code
);
  logic               rst_start, exec_st;
  logic [NUM_SRC-1:0] req, gnt_d, grant_q;
  logic [CODE_W-1:0]  idx_d, code_q;

  exc_reset_ctl u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_pin    (res_pin),
    .wdt_ovf    (wdt_ovf),
    .nmi_pin    (nmi_pin),
    .rst_start  (rst_start),
    .exec_st    (exec_st),
    .rst_is_por (rst_is_por)
  );

  exc_req_qual #(.MODE_W(MODE_W), .TRACE_MODE(TRACE_MODE)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_st    (exec_st),
    .rst_start  (rst_start),
    .bnd_valid  (bnd_valid),
    .bnd_kind   (bnd_kind),
    .busy       (busy),
    .trace_flag (trace_flag),
    .intm       (intm),
    .irq_pend   (irq_pend),
    .trap_req   (trap_req),
    .trap_taken (gnt_d[EXC_TRAP]),
    .req        (req)
  );

  exc_prio_enc #(.N(NUM_SRC)) u_prio (
    .req (req),
    .gnt (gnt_d),
    .idx (idx_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      code_q  <= '0;
    end else begin
      grant_q <= gnt_d;
      code_q  <= idx_d;
    end
  end

  assign grant    = grant_q;
  assign exc_code = code_q;
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk
  import exc_arb_pkg::*;
#(
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned TRACE_MODE = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               res_pin,
  input logic               nmi_pin,
  input logic               irq_pend,
  input logic               trace_flag,
  input logic [MODE_W-1:0]  intm,
  input logic               bnd_valid,
  input logic [KIND_W-1:0]  bnd_kind,
  input logic               busy,
  input logic [NUM_SRC-1:0] grant,
  input logic               rst_is_por,
  input logic [CODE_W-1:0]  exc_code
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_onehot_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_code_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> grant[exc_code]);
  assert_rise_starts_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(res_pin)) |=> grant[EXC_RESET]);
  assert_por_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EXC_RESET] |-> (rst_is_por == $past(nmi_pin)));
  assert_trace_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EXC_TRACE] |-> ($past(trace_flag) && ($past(intm) == MODE_W'(TRACE_MODE))));
  assert_no_trace_after_rte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EXC_TRACE] |-> ($past(bnd_kind) != KIND_RET_EXC));
  assert_irq_sampling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant[EXC_IRQ] |-> ($past(irq_pend) && $past(bnd_kind) != KIND_CCR_MOD
                        && $past(bnd_kind) != KIND_RST_DONE));
  assert_boundary_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant[EXC_TRACE] || grant[EXC_IRQ] || grant[EXC_TRAP])
      |-> ($past(bnd_valid) && !$past(busy)));
  assert_pin_low_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_pin |=> (grant == '0));
endmodule

bind exc_arbiter exc_arbiter_chk #(.MODE_W(MODE_W), .TRACE_MODE(TRACE_MODE)) u_chk (.*);

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       res_pin, wdt_ovf, nmi_pin, irq_pend, trap_req, trace_flag;
  logic [1:0] intm;
  logic       bnd_valid;
  logic [2:0] bnd_kind;
  logic       busy;
  logic [3:0] grant;
  logic       rst_is_por;
  logic [1:0] exc_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic       m_resq, m_armed, m_trap, m_por;
  logic [3:0] e_grant;
  logic [1:0] e_code;

  always #2 clk = ~clk;

  exc_arbiter u0 (.*);

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic ex, rs, ok, tr, iq, tp;
    string t;
    ex = m_armed && res_pin;
    rs = (res_pin && !m_resq) || (wdt_ovf && ex);
    ok = bnd_valid && ex && !busy && !rs;
    tr = trace_flag && intm == 2'd2 && bnd_kind != 3'd2;
    iq = irq_pend && bnd_kind != 3'd1 && bnd_kind != 3'd3;
    tp = ex && (m_trap || trap_req);
    e_grant = 4'b0000; e_code = 2'd0;
    if (rs)            begin e_grant = 4'b0001; e_code = 2'd0; end
    else if (ok && tr) begin e_grant = 4'b0010; e_code = 2'd1; end
    else if (ok && iq) begin e_grant = 4'b0100; e_code = 2'd2; end
    else if (ok && tp) begin e_grant = 4'b1000; e_code = 2'd3; end
    m_trap = (!ex || rs) ? 1'b0 : (tp && !e_grant[3]);
    if (rs) begin m_por = nmi_pin; m_armed = 1'b1; end
    m_resq = res_pin;
    @(negedge clk);
    t = tag;
    if (t == "") begin
      if (e_grant[0]) t = "R3";
      else if (e_grant[1]) t = "R5";
      else if (e_grant[2]) t = "R7";
      else if (e_grant[3]) t = "R8";
      else t = "R9";
    end
    chk(t, "grant", grant, e_grant);
    chk("R1", "exc_code", exc_code, e_code);
    chk("R4", "rst_is_por", rst_is_por, m_por);
    bnd_valid = 0; trap_req = 0; wdt_ovf = 0;
  endtask

  task automatic bnd(logic [2:0] kind, string tag);
    bnd_valid = 1; bnd_kind = kind;
    step(tag);
  endtask

  initial begin
    int n;
    n = 0;
    while (!done && n < 200000) begin @(posedge clk); n++; end
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7341));
    rst_n = 0; res_pin = 1; wdt_ovf = 0; nmi_pin = 1; irq_pend = 0; trap_req = 0;
    trace_flag = 0; intm = 0; bnd_valid = 0; bnd_kind = 0; busy = 0;
    m_resq = 1; m_armed = 0; m_trap = 0; m_por = 1;
    repeat (3) @(negedge clk);
    chk("R10", "grant in reset", grant, 0);
    chk("R4", "por after reset", rst_is_por, 1);
    rst_n = 1;
    // not armed yet: nothing granted (R10)
    irq_pend = 1; trap_req = 1; bnd(3'd0, "R10");
    bnd(3'd0, "R10");
    res_pin = 0; bnd(3'd0, "R10");
    step("R10");
    res_pin = 1; nmi_pin = 1; step("R3");           // reset start, power-on (R4)
    bnd(3'd3, "R7");                                 // no irq after reset done
    bnd(3'd0, "R7");                                 // irq taken now
    bnd(3'd1, "R7");                                 // not after ccr modify
    // priority R2
    intm = 2; trace_flag = 1; trap_req = 1; bnd(3'd0, "R2");
    trace_flag = 0; bnd(3'd0, "R2");
    irq_pend = 0; bnd(3'd0, "R2");
    // trace mode and return rules
    trace_flag = 1; intm = 0; bnd(3'd0, "R5");
    intm = 3; bnd(3'd4, "R5");
    intm = 2; bnd(3'd2, "R6");
    bnd(3'd0, "R5");
    trace_flag = 0;
    // busy holds off (R9)
    irq_pend = 1; busy = 1; bnd(3'd0, "R9");
    busy = 0; step("R9");
    bnd(3'd0, "R7");
    irq_pend = 0;
    // watchdog manual reset, busy ignored (R3, R4)
    nmi_pin = 0; busy = 1; wdt_ovf = 1; step("R4");
    busy = 0;
    // trap never masked (R8)
    intm = 0; trap_req = 1; bnd(3'd1, "R8");
    trap_req = 1; step("R8");
    bnd(3'd2, "R8");
    // latched trap discarded by reset pin (R10)
    trap_req = 1; step("R10");
    res_pin = 0; step("R10");
    res_pin = 1; nmi_pin = 1; step("R3");
    bnd(3'd0, "R10");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (!res_pin) res_pin = ($urandom % 4 == 0);
      else          res_pin = ($urandom % 150 != 0);
      wdt_ovf    = ($urandom % 64 == 0);
      nmi_pin    = $urandom % 2;
      irq_pend   = ($urandom % 3 == 0);
      trap_req   = ($urandom % 8 == 0);
      trace_flag = ($urandom % 4 == 0);
      intm       = 2'($urandom % 4);
      bnd_valid  = $urandom % 2;
      bnd_kind   = 3'($urandom % 8);
      busy       = ($urandom % 5 == 0);
      step("");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule